// File: doc/BRIEF.md
# Egress Dual-Plane Merge Lock Controller

This controller sits in an egress adapter that is fed by redundant switch planes. It keeps packet order intact when traffic moves from one color to the other. A switchover command names the plane that stays active. Every other plane then becomes a peer, and the controller holds the buffer of each peer plane locked so that its data is not forwarded. The expected packet color flips to the new value when the command is taken.

While the lock is held, the controller waits for two things. The first is an idle packet that carries the new color and arrives from the active plane. The second is that the active plane's queue toward the traffic manager is empty. When both have happened, the lock is released and a done status is raised for the local processor. A marker that arrives early is remembered, so the release can follow a later drain.

The machine has three states. ST_OPEN means no phase is in progress and nothing is locked. ST_AWAIT_MARK means the lock is held and no marker has been seen yet. ST_AWAIT_DRAIN means the lock is held, the marker has been seen, and the queue is still not empty. The transitions are:

- T_START goes from ST_OPEN to ST_AWAIT_MARK on a command.
- T_MARK goes from ST_AWAIT_MARK to ST_AWAIT_DRAIN when a marker arrives and the queue is not empty.
- T_MARK_EMPTY goes from ST_AWAIT_MARK to ST_OPEN when a marker arrives and the queue is already empty.
- T_DRAIN goes from ST_AWAIT_DRAIN to ST_OPEN when the queue becomes empty.
- A command that arrives in either await state is rejected (T_REJECT). The state does not change.

Top module: `merge_lock_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, peer_lock is all zeros and stat_color, stat_done and stat_err are all 0.
- R2: A sw_req that arrives when nothing is locked is accepted. From the next cycle, peer_lock has a 1 for every plane except the plane given by sw_plane, and a 0 for that plane. stat_color inverts, and stat_done and stat_err clear.
- R3: A packet counts as a marker only when all of these hold: valid=1, idle flag=1, and its color bit equals stat_color. It must also come from the active plane while the lock is held. Data packets, idle packets of the old color, packets from locked planes, and packets that arrive in the same cycle as the command do not count.
- R4: The lock is released only when a marker has been seen and queue_empty of the active plane is 1. If both happen in the same cycle, peer_lock is all zeros from the next cycle. The queue_empty inputs of the peer planes have no effect.
- R5: A marker is remembered until release. If the queue becomes empty in a later cycle, the lock is released in the cycle after that.
- R6: An empty active queue with no marker yet seen does not release the lock.
- R7: stat_done rises in the same cycle the lock falls. It stays at 1 until the next accepted command.
- R8: A sw_req that arrives while the lock is held is ignored. Lock, active plane and stat_color are unchanged. stat_err is set from the next cycle and stays set until the next accepted command, even if a release happens in that same cycle.
- R9: Successive accepted commands alternate the expected color. The first command after reset expects color 1 and the second expects color 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req | input | 1 | Switchover command strobe |
| sw_plane | input | SEL_W | Index of the plane that stays active |
| pkt_vld | input | N_PLANES | Per-plane packet valid |
| pkt_color | input | N_PLANES | Per-plane packet color bit |
| pkt_idle | input | N_PLANES | Per-plane flag: 1 = idle packet, 0 = data packet |
| queue_empty | input | N_PLANES | Per-plane queue toward the traffic manager is empty |
| peer_lock | output | N_PLANES | Per-plane buffer lock: 1 = hold this plane's data |
| stat_color | output | 1 | Expected (new) color |
| stat_locked | output | 1 | Some peer buffer is locked |
| stat_done | output | 1 | Last phase completed |
| stat_err | output | 1 | Command was rejected while a phase was in progress |

## Verification
Three pairs of events can fall in the same cycle.

- A marker and the active queue draining can coincide. The bench drives both together and expects the lock to fall at the very next edge.
- A command can meet a marker that is already on the wire. Here the marker must be ignored, and the lock must still be held after a later empty queue.
- A rejected command can coincide with the drain that completes the phase. The bench expects the release and the done bit, and also expects the error flag with the color unchanged.

// File: rtl/merge_lock_pkg.sv
package merge_lock_pkg;

    typedef enum logic [1:0] {
        ST_OPEN        = 2'd0,
        ST_AWAIT_MARK  = 2'd1,
        ST_AWAIT_DRAIN = 2'd2
    } mlk_state_e;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mlk_marker_detect.sv
module mlk_marker_detect #(
    parameter int N_PLANES = 2
) (
    input  logic [N_PLANES-1:0] pkt_vld,
    input  logic [N_PLANES-1:0] pkt_color,
    input  logic [N_PLANES-1:0] pkt_idle,
    input  logic                exp_color,
    output logic [N_PLANES-1:0] mark_hit
);

    // one comparator per plane: valid idle packet of the expected color
    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        assign mark_hit[p] = pkt_vld[p] & pkt_idle[p] & (pkt_color[p] == exp_color);
    end

endmodule

// File: rtl/mlk_lock_decode.sv
module mlk_lock_decode #(
    parameter int N_PLANES = 2,
    localparam int SEL_W = merge_lock_pkg::sel_width(N_PLANES)
) (
    input  logic                busy,
    input  logic [SEL_W-1:0]    active_plane,
    output logic [N_PLANES-1:0] peer_lock
);

    // every plane other than the active one is held while a phase runs
    for (genvar p = 0; p < N_PLANES; p++) begin : g_lock
        assign peer_lock[p] = busy && (active_plane != SEL_W'(p));
    end

endmodule

// File: rtl/mlk_fsm.sv
module mlk_fsm
    import merge_lock_pkg::*;
#(
    parameter int N_PLANES = 2,
    localparam int SEL_W = sel_width(N_PLANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_req,
    input  logic [SEL_W-1:0]    sw_plane,
    input  logic [N_PLANES-1:0] mark_hit,
    input  logic [N_PLANES-1:0] queue_empty,
    output logic [SEL_W-1:0]    active_plane,
    output logic                busy,
    output logic                exp_color,
    output logic                done,
    output logic                err
);

    mlk_state_e       state_q, state_d;
    logic [SEL_W-1:0] act_q, act_d;
    logic             color_q, color_d;
    logic             done_q, done_d;
    logic             err_q, err_d;
    logic             mark_act;
    logic             empty_act;

    assign mark_act  = mark_hit[act_q];
    assign empty_act = queue_empty[act_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            act_q   <= '0;
            color_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            color_q <= color_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        color_d = color_q;
        done_d  = done_q;
        err_d   = err_q;
        unique case (state_q)
            ST_OPEN: begin
                if (sw_req) begin            // T_START
                    state_d = ST_AWAIT_MARK;
                    act_d   = sw_plane;
                    color_d = ~color_q;
                    done_d  = 1'b0;
                    err_d   = 1'b0;
                end
            end
            ST_AWAIT_MARK: begin
                if (sw_req) err_d = 1'b1;    // T_REJECT
                if (mark_act) begin
                    if (empty_act) begin     // T_MARK_EMPTY
                        state_d = ST_OPEN;
                        done_d  = 1'b1;
                    end else begin           // T_MARK
                        state_d = ST_AWAIT_DRAIN;
                    end
                end
            end
            ST_AWAIT_DRAIN: begin
                if (sw_req) err_d = 1'b1;    // T_REJECT
                if (empty_act) begin         // T_DRAIN
                    state_d = ST_OPEN;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_OPEN);
        active_plane = act_q;
        exp_color    = color_q;
        done         = done_q;
        err          = err_q;
    end

endmodule

// File: rtl/merge_lock_ctrl.sv
module merge_lock_ctrl #(
    parameter int N_PLANES = 2,
    localparam int SEL_W = merge_lock_pkg::sel_width(N_PLANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_req,
    input  logic [SEL_W-1:0]    sw_plane,
    input  logic [N_PLANES-1:0] pkt_vld,
    input  logic [N_PLANES-1:0] pkt_color,
    input  logic [N_PLANES-1:0] pkt_idle,
    input  logic [N_PLANES-1:0] queue_empty,
    output logic [N_PLANES-1:0] peer_lock,
    output logic                stat_color,
    output logic                stat_locked,
    output logic                stat_done,
    output logic                stat_err
);

    logic [N_PLANES-1:0] mark_hit;
    logic [SEL_W-1:0]    active_plane;
    logic                busy;

    mlk_marker_detect #(.N_PLANES(N_PLANES)) u_mark (
        .pkt_vld   (pkt_vld),
        .pkt_color (pkt_color),
        .pkt_idle  (pkt_idle),
        .exp_color (stat_color),
        .mark_hit  (mark_hit)
    );

    mlk_fsm #(.N_PLANES(N_PLANES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_req       (sw_req),
        .sw_plane     (sw_plane),
        .mark_hit     (mark_hit),
        .queue_empty  (queue_empty),
        .active_plane (active_plane),
        .busy         (busy),
        .exp_color    (stat_color),
        .done         (stat_done),
        .err          (stat_err)
    );

    mlk_lock_decode #(.N_PLANES(N_PLANES)) u_lock (
        .busy         (busy),
        .active_plane (active_plane),
        .peer_lock    (peer_lock)
    );

    assign stat_locked = |peer_lock;

endmodule

// File: rtl/merge_lock_ctrl_chk.sv
module merge_lock_ctrl_chk #(
    parameter int N_PLANES = 2,
    localparam int SEL_W = merge_lock_pkg::sel_width(N_PLANES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sw_req,
    input logic [N_PLANES-1:0] queue_empty,
    input logic [N_PLANES-1:0] peer_lock,
    input logic [SEL_W-1:0]    act_plane,
    input logic                stat_color,
    input logic                stat_locked,
    input logic                stat_done,
    input logic                stat_err
);

    // R2
    lock_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(peer_lock) == 0) || ($countones(peer_lock) == N_PLANES - 1));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_locked && sw_req) |=> (stat_locked && (stat_color != $past(stat_color)) && !stat_done && !stat_err));

    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_locked && sw_req) |=> (stat_err && (stat_color == $past(stat_color))));

    // R4
    hold_until_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_locked && !queue_empty[act_plane]) |=> stat_locked);

    // R7
    done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_locked) |-> stat_done);

    // R9
    color_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_color) |-> $past(sw_req && !stat_locked));

endmodule

bind merge_lock_ctrl merge_lock_ctrl_chk #(.N_PLANES(N_PLANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .queue_empty (queue_empty),
    .peer_lock   (peer_lock),
    .act_plane   (active_plane),
    .stat_color  (stat_color),
    .stat_locked (stat_locked),
    .stat_done   (stat_done),
    .stat_err    (stat_err)
);

// File: tb/merge_lock_ctrl_tb.sv
module merge_lock_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_req = 1'b0;
    logic [0:0] sw_plane = '0;
    logic [1:0] pkt_vld = '0, pkt_color = '0, pkt_idle = '0, queue_empty = '0;
    logic [1:0] peer_lock;
    logic       stat_color, stat_locked, stat_done, stat_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    merge_lock_ctrl #(.N_PLANES(2)) u_dut (
        .clk, .rst_n, .sw_req, .sw_plane, .pkt_vld, .pkt_color, .pkt_idle,
        .queue_empty, .peer_lock, .stat_color, .stat_locked, .stat_done, .stat_err
    );

    // fields: req, plane, vld[2], color[2], idle[2], qempty[2] | lock[2], color, done, err
    localparam logic [14:0] VEC [NV] = '{
        15'b1_0_00_00_00_00_10_1_0_0,
        15'b0_0_01_01_00_01_10_1_0_0,
        15'b0_0_01_00_01_01_10_1_0_0,
        15'b0_0_10_10_10_11_10_1_0_0,
        15'b1_1_00_00_00_00_10_1_0_1,
        15'b0_0_01_01_01_00_10_1_0_1,
        15'b0_0_00_00_00_10_10_1_0_1,
        15'b0_0_00_00_00_01_00_1_1_1,
        15'b0_0_00_00_00_00_00_1_1_1,
        15'b1_1_00_00_00_00_01_0_0_0,
        15'b0_0_10_00_10_10_00_0_1_0,
        15'b0_0_00_00_00_00_00_0_1_0
    };
    string tags [NV] = '{"R2", "R3", "R3", "R6", "R8", "R5", "R4", "R7", "R7", "R9", "R4", "R7"};

    task automatic check(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {peer_lock, stat_color, stat_done, stat_err};
        n_cmp++;
        if (act !== exp || stat_locked !== (|exp[4:3])) begin
            n_bad++;
            $display("FAIL %s: got lock/color/done/err=%b locked=%b, expected %b", tag, act, stat_locked, exp);
        end
    endtask

    task automatic apply(input logic req, input logic pl, input logic [1:0] v,
                         input logic [1:0] c, input logic [1:0] i, input logic [1:0] q);
        @(negedge clk);
        sw_req = req; sw_plane = pl; pkt_vld = v; pkt_color = c; pkt_idle = i; queue_empty = q;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 5'b00_0_0_0);          // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 5'b00_0_0_0);          // R1 after release

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][14], VEC[k][13], VEC[k][12:11], VEC[k][10:9], VEC[k][8:7], VEC[k][6:5]);
            check(tags[k], VEC[k][4:0]);
        end

        // R3: a marker that coincides with the command does not count
        apply(1'b1, 1'b0, 2'b01, 2'b01, 2'b01, 2'b00);
        check("R3", 5'b10_1_0_0);
        // R6: the queue empties later, but no marker has been seen
        apply(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01);
        check("R6", 5'b10_1_0_0);
        // R5: marker with the queue still busy
        apply(1'b0, 1'b0, 2'b01, 2'b01, 2'b01, 2'b00);
        check("R5", 5'b10_1_0_0);
        // R8: rejected command in the same cycle as the completing drain
        apply(1'b1, 1'b1, 2'b00, 2'b00, 2'b00, 2'b01);
        check("R8", 5'b00_1_1_1);
        // R9: the next phase expects color 0 and clears the flags
        apply(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00);
        check("R9", 5'b10_0_0_0);
        // R1: reset in the middle of a phase
        @(negedge clk);
        rst_n = 1'b0;
        sw_req = 1'b0;
        #1;
        check("R1", 5'b00_0_0_0);

        finish_run();
    end

endmodule